// File: doc/BRIEF.md
# Masked Content-Addressable Match Array

This block is an associative store of a parameterised number of words, each a parameterised number of bits wide. Software or a neighbouring engine writes words into numbered slots and can read any slot back. The main use is the search: a pattern held in an argument register is compared against every stored word at once. A key register chooses which bit positions take part in the compare. The result lands in a match register that has one bit per slot, so every slot that agrees on all selected positions is reported together.

Each slot carries a valid flag. A slot whose flag is clear never reports a match, and reset clears every flag. A write may store a word as valid or mark a slot invalid. Inside one clock cycle the block applies operations in a fixed order. First the write and any loads of argument or key take effect. Then the search compares against the updated contents. The match register changes on the clock edge that samples the search strobe and keeps its value until the next search.

Top module: `assoc_match_array`

## Requirements
- R1: During and after reset every slot is invalid and `match_o` is all zeros. A search issued before any write therefore returns all zeros, whatever the key.
- R2: When `wr_en` is high at a clock edge, slot `wr_idx` takes `wr_data` and takes `wr_valid` as its valid flag. When `rd_en` is high at an edge, `rd_data` and `rd_valid` show that slot's word and flag after that same edge and hold until the next read.
- R3: When `search` is high at a clock edge, bit i of `match_o` becomes 1 after that edge exactly when slot i is valid and ((word XOR argument) AND key) is zero.
- R4: Key bit j equal to 1 means bit position j is compared. Key bit j equal to 0 means position j is ignored. A key of all zeros matches every valid slot. After reset the key is all ones and the argument is zero.
- R5: A slot written with `wr_valid` equal to 0 becomes invalid and never matches, even when its stored bits agree with the argument.
- R6: On a clock edge where `search` is low, `match_o` keeps its value.
- R7: A write and a search in the same cycle are serialised with the write first: the search sees the newly written word and valid flag.
- R8: `arg_load` and `key_load` replace the argument and key registers at the edge. A search in the same cycle uses the newly loaded values. A load without a search leaves `match_o` unchanged.
- R9: All matching slots are reported at once, with no priority among them: several 1 bits may be set in `match_o`.
- R10: A read and a write to the same slot in the same cycle return the contents held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Slot written |
| wr_data | input | WIDTH | Word written |
| wr_valid | input | 1 | Valid flag stored with the word |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | IDX_W | Slot read |
| rd_data | output | WIDTH | Registered read word |
| rd_valid | output | 1 | Registered valid flag of the slot read |
| arg_load | input | 1 | Load the argument register |
| arg_in | input | WIDTH | New argument value |
| key_load | input | 1 | Load the key register |
| key_in | input | WIDTH | New key value |
| search | input | 1 | Search strobe |
| match_o | output | WORDS | Match register, bit i for slot i |

## Verification
The assertions check four behaviours on every clock cycle. The match vector holds between searches. An invalid slot never reports a hit. A valid slot always hits under an all-zero key. The match vector is zero after reset. The behaviours that depend on an ordering inside one cycle can only be shown by the bench's scenarios. These are a write landing before the search in the same cycle, a load of argument or key landing before a search, a read that returns the old word while that slot is being written, and several duplicate slots all reported together. The bench's scenarios also cover exact-match results under partial keys, which the assertions do not check.

// File: rtl/cam_pkg.sv
package cam_pkg;

   // Widest word the shared compare helper accepts.
   localparam int CAM_MAX_WIDTH = 64;

   typedef logic [CAM_MAX_WIDTH-1:0] cam_bits_t;

   // A valid word hits when every position selected by the key agrees.
   function automatic logic masked_hit(input cam_bits_t word,
                                       input logic      valid,
                                       input cam_bits_t arg,
                                       input cam_bits_t key);
      return valid && (((word ^ arg) & key) == '0);
   endfunction

endpackage

// File: rtl/assoc_query_regs.sv
module assoc_query_regs #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arg_load,
   input  logic [WIDTH-1:0] arg_in,
   input  logic             key_load,
   input  logic [WIDTH-1:0] key_in,
   output logic [WIDTH-1:0] arg_eff,
   output logic [WIDTH-1:0] key_eff
);

   logic [WIDTH-1:0] arg_q;
   logic [WIDTH-1:0] key_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arg_q <= '0;
         key_q <= '1;
      end else begin
         if (arg_load) arg_q <= arg_in;
         if (key_load) key_q <= key_in;
      end
   end

   // A load in the same cycle as a search is seen by that search.
   assign arg_eff = arg_load ? arg_in : arg_q;
   assign key_eff = key_load ? key_in : key_q;

endmodule

// File: rtl/assoc_entry.sv
module assoc_entry #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             wr_valid,
   input  logic             search,
   input  logic [WIDTH-1:0] arg_eff,
   input  logic [WIDTH-1:0] key_eff,
   output logic [WIDTH-1:0] word_q,
   output logic             valid_q,
   output logic             match_q
);

   logic [WIDTH-1:0] word_eff;
   logic             valid_eff;

   // Write first: the search of the same cycle compares the incoming word.
   assign word_eff  = wr_sel ? wr_data  : word_q;
   assign valid_eff = wr_sel ? wr_valid : valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         valid_q <= 1'b0;
         match_q <= 1'b0;
      end else begin
         if (wr_sel) begin
            word_q  <= wr_data;
            valid_q <= wr_valid;
         end
         if (search) begin
            match_q <= cam_pkg::masked_hit(cam_pkg::CAM_MAX_WIDTH'(word_eff), valid_eff,
                                           cam_pkg::CAM_MAX_WIDTH'(arg_eff),
                                           cam_pkg::CAM_MAX_WIDTH'(key_eff));
         end
      end
   end

   // R5: an invalid slot never reports a hit
   p_invalid_nohit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (search && !valid_eff) |=> !match_q);

   // R4: an all-zero key hits every valid slot
   p_zero_key_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (search && valid_eff && (key_eff == '0)) |=> match_q);

endmodule

// File: rtl/assoc_match_array.sv
module assoc_match_array #(
   parameter  int WORDS = 16,
   parameter  int WIDTH = 8,
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             wr_valid,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_valid,
   input  logic             arg_load,
   input  logic [WIDTH-1:0] arg_in,
   input  logic             key_load,
   input  logic [WIDTH-1:0] key_in,
   input  logic             search,
   output logic [WORDS-1:0] match_o
);

   // Elaboration-time parameter checks
   if (WORDS < 2) begin : g_bad_words
      $error("assoc_match_array: WORDS must be at least 2");
   end
   if (WIDTH < 1 || WIDTH > cam_pkg::CAM_MAX_WIDTH) begin : g_bad_width
      $error("assoc_match_array: WIDTH out of range");
   end

   logic [WIDTH-1:0] arg_eff;
   logic [WIDTH-1:0] key_eff;
   logic [WIDTH-1:0] words  [WORDS];
   logic [WORDS-1:0] valids;

   assoc_query_regs #(.WIDTH(WIDTH)) u_query (
      .clk      (clk),
      .rst_n    (rst_n),
      .arg_load (arg_load),
      .arg_in   (arg_in),
      .key_load (key_load),
      .key_in   (key_in),
      .arg_eff  (arg_eff),
      .key_eff  (key_eff)
   );

   for (genvar i = 0; i < WORDS; i++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(i));
      assoc_entry #(.WIDTH(WIDTH)) u_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_sel   (sel),
         .wr_data  (wr_data),
         .wr_valid (wr_valid),
         .search   (search),
         .arg_eff  (arg_eff),
         .key_eff  (key_eff),
         .word_q   (words[i]),
         .valid_q  (valids[i]),
         .match_q  (match_o[i])
      );
   end

   // Registered read: it samples the contents held before this edge's write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else if (rd_en) begin
         if (int'(rd_idx) < WORDS) begin
            rd_data  <= words[rd_idx];
            rd_valid <= valids[rd_idx];
         end else begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
         end
      end
   end

   // R6: the match register holds between searches
   p_match_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !search |=> $stable(match_o));

   // R1: reset leaves an empty match register
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (match_o == '0));

endmodule

// File: tb/assoc_match_array_bench.sv
`timescale 1ns/1ps
module assoc_match_array_bench;

   localparam int M  = 16;
   localparam int W  = 8;
   localparam int IW = $clog2(M);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, wr_valid = 1'b0, rd_en = 1'b0;
   logic [IW-1:0] wr_idx = '0, rd_idx = '0;
   logic [W-1:0]  wr_data = '0, arg_in = '0, key_in = '0;
   logic          arg_load = 1'b0, key_load = 1'b0, search = 1'b0;
   logic [W-1:0]  rd_data;
   logic          rd_valid;
   logic [M-1:0]  match_o;

   always #10 clk = ~clk;  // 50 MHz

   assoc_match_array #(.WORDS(M), .WIDTH(W)) u_assoc_match_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_valid(wr_valid),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
      .arg_load(arg_load), .arg_in(arg_in), .key_load(key_load), .key_in(key_in),
      .search(search), .match_o(match_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Reference model built from the requirements
   logic [W-1:0] m_word [M];
   logic         m_val  [M];
   logic [W-1:0] m_arg = '0;
   logic [W-1:0] m_key = '1;
   logic [M-1:0] m_match = '0;

   logic [M-1:0] q_exp [$];
   string        q_tag [$];

   function automatic logic [M-1:0] model_search();
      logic [M-1:0] r;
      for (int i = 0; i < M; i++)
         r[i] = m_val[i] && (((m_word[i] ^ m_arg) & m_key) == '0);
      return r;
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: compare each search result one half cycle after its edge
   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         logic [M-1:0] e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         check(32'(match_o), 32'(e), t);
      end
   end

   // Driver: one cycle of stimulus, called just after a falling edge
   task automatic step(input logic we, input int wi, input logic [W-1:0] wd, input logic wv,
                       input logic al, input logic [W-1:0] av,
                       input logic kl, input logic [W-1:0] kv,
                       input logic sr, input string tag);
      wr_en = we; wr_idx = IW'(wi); wr_data = wd; wr_valid = wv;
      arg_load = al; arg_in = av; key_load = kl; key_in = kv; search = sr;
      if (we) begin m_word[wi] = wd; m_val[wi] = wv; end
      if (al) m_arg = av;
      if (kl) m_key = kv;
      @(posedge clk);
      if (sr) begin
         m_match = model_search();
         q_exp.push_back(m_match);
         q_tag.push_back(tag);
      end
      @(negedge clk);
      wr_en = 0; arg_load = 0; key_load = 0; search = 0;
   endtask

   task automatic do_write(input int i, input logic [W-1:0] d, input logic v);
      step(1, i, d, v, 0, '0, 0, '0, 0, "");
   endtask

   task automatic do_search(input logic [W-1:0] a, input logic [W-1:0] k, input string tag);
      step(0, 0, '0, 0, 1, a, 1, k, 1, tag);
   endtask

   task automatic do_read(input int i, input string tag);
      rd_en = 1; rd_idx = IW'(i);
      @(posedge clk);
      @(negedge clk);
      rd_en = 0;
      check(32'({rd_valid, rd_data}), 32'({m_val[i], m_word[i]}), tag);
   endtask

   initial begin
      for (int i = 0; i < M; i++) begin m_word[i] = '0; m_val[i] = 1'b0; end
      repeat (3) @(negedge clk);
      check(32'(match_o), 32'h0, "R1 match zero in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(32'(match_o), 32'h0, "R1 match zero after reset");
      do_search(8'h00, 8'h00, "R1 zero-key search on empty store");
      do_read(4, "R1 slot invalid after reset");

      // Fill the store; slot 5 stored invalid
      for (int i = 0; i < M; i++) do_write(i, W'(i * 17) ^ 8'h5A, i != 5);
      do_read(3, "R2 read slot 3");
      do_read(5, "R2 read invalid slot 5");
      do_read(15, "R2 read slot 15");

      do_search(m_word[7], 8'hFF, "R3 exact search slot 7");
      do_search(m_word[12], 8'hFF, "R3 exact search slot 12");
      do_search(8'h00, 8'h00, "R4 zero key hits all valid");
      do_search(8'hA0, 8'hF0, "R4 upper nibble compare");
      do_search(8'h0B, 8'h0F, "R4 lower nibble compare");

      do_search(m_word[5], 8'hFF, "R5 invalid slot 5 never hits");
      do_write(3, m_word[3], 1'b0);
      do_search(m_word[3], 8'hFF, "R5 slot 3 after invalidation");

      do_write(3, 8'hC3, 1'b1);
      do_write(9, 8'hC3, 1'b1);
      do_write(11, 8'hC7, 1'b1);
      do_search(8'hC3, 8'hFF, "R9 duplicate slots 3 and 9");
      do_search(8'hC3, 8'hFB, "R9 three slots under partial key");

      repeat (4) @(negedge clk);
      check(32'(match_o), 32'(m_match), "R6 match held while idle");

      step(1, 6, 8'h77, 1, 1, 8'h77, 1, 8'hFF, 1, "R7 write then search same cycle");
      step(1, 6, 8'h78, 0, 0, '0, 0, '0, 1, "R7 invalidating write seen by search");

      step(0, 0, '0, 0, 1, 8'hC7, 0, '0, 1, "R8 argument load with search");
      step(0, 0, '0, 0, 1, 8'h00, 1, 8'h00, 0, "");
      check(32'(match_o), 32'(m_match), "R8 load without search keeps match");
      step(0, 0, '0, 0, 0, '0, 0, '0, 1, "R8 search uses loaded arg and key");

      // R10: read and write the same slot in one cycle
      rd_en = 1; rd_idx = IW'(2);
      wr_en = 1; wr_idx = IW'(2); wr_data = 8'hEE; wr_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 0; wr_en = 0;
      check(32'({rd_valid, rd_data}), 32'({m_val[2], m_word[2]}), "R10 read returns old word");
      m_word[2] = 8'hEE; m_val[2] = 1'b1;
      do_read(2, "R10 new word after write");

      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule